// File: doc/BRIEF.md
# I/O Port Window Decoder with Interrupt Line Routing

This block owns the I/O port space of a small peripheral fabric. While the fabric is being configured, a registration interface enrolls devices one at a time and gives them I/O windows. Each enrolled device gets the next free device number. A device that asks for an interrupt also gets the next free legacy line from a fixed ordered pool. Each window receives the current base of a bump allocator, and the allocator base then moves forward by one window size. Every window has the same size.

At run time, each port access is compared in parallel against every window that has been enrolled with a handler attached. On a hit, the block reports which device and which window were hit, and the offset of the port inside that window. On a miss, a read returns all-ones and a write goes nowhere. The interrupt request bit of the device that was hit is translated into that device's assigned line number. The value 0xFF means "no interrupt". A separate combinational query port returns the line assigned to any device number.

Top module: `ioport_router`

## Requirements
- R1: Adding a device (`reg_op`=0) succeeds while fewer than `N_DEV` devices are enrolled, and returns the enrolled count as the new device number. Once `N_DEV` devices exist, any further add fails.
- R2: A device added with `reg_irq_need`=1 receives the next line from the pool 3, 5, 6, 7, 9, 10, 11, 12, 14, 15, in that order. Once all ten lines are taken, such an add fails, but an add without an interrupt still succeeds. A device without an interrupt reports 0xFF in `rsp_irq`.
- R3: `qry_irq` returns the line assigned to device `qry_dev`. It returns 0xFF for a device that has no line or is not enrolled.
- R4: Adding a window (`reg_op`=1) fails if `reg_dev` is not an enrolled device number, or if that device already holds `N_BAR` windows.
- R5: A successful window add returns in `rsp_base` the allocator base, which starts at `BASE_LO`. The base then advances by `WIN`. A window add fails once the allocator base has reached `BASE_HI`. On success, `rsp_bar` is the window's index within the device, counted from 0.
- R6: An access hits a window when base ≤ port < base + `WIN` and that window was added with `reg_hdl`=1. The result carries the device number, the window index and the offset port − base.
- R7: When no window hits, the result has `out_hit`=0. A read (`acc_write`=0) returns `out_rdata`=0xFFFFFFFF, and a write returns `out_rdata`=0 and is not forwarded.
- R8: `out_irq` equals the assigned line of the device that was hit when that device's bit in `dev_intr` is 1. In every other case, including a miss, it is 0xFF.
- R9: Every registration request gets exactly one response (`rsp_valid`) one cycle later. Every access gets exactly one result (`out_valid`) one cycle later. After reset, neither output is valid and the allocator has handed nothing out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Registration request strobe |
| reg_op | input | 1 | 0 = add device, 1 = add window |
| reg_irq_need | input | 1 | Device add asks for an interrupt line |
| reg_dev | input | DEV_W | Target device for window add |
| reg_hdl | input | 1 | Window add attaches a handler |
| rsp_valid | output | 1 | Registration response valid |
| rsp_ok | output | 1 | Registration succeeded |
| rsp_dev | output | DEV_W | New device number, or echoed target device |
| rsp_bar | output | BAR_W | Index of the new window |
| rsp_base | output | PORT_W | Base given to the new window |
| rsp_irq | output | 8 | Line given to the new device, or 0xFF |
| qry_dev | input | DEV_W | Device number for the line query |
| qry_irq | output | 8 | Line of `qry_dev`, or 0xFF |
| acc_valid | input | 1 | Port access strobe |
| acc_write | input | 1 | Access is a write |
| acc_port | input | PORT_W | Accessed port |
| dev_intr | input | N_DEV | Per-device interrupt request bits |
| out_valid | output | 1 | Access result valid |
| out_hit | output | 1 | Access hit a window |
| out_dev | output | DEV_W | Device that was hit |
| out_bar | output | BAR_W | Window that was hit |
| out_ofs | output | OFS_W | Offset inside the window |
| out_rdata | output | 32 | All-ones on a read miss, otherwise 0 |
| out_irq | output | 8 | Routed line or 0xFF |

## Verification
The assertions assume that `reg_req` and `acc_valid` are single-cycle strobes that can be issued every cycle. They also assume that the allocator only moves forward between resets, and that the enrolled count and line index never go past their limits. The bench keeps every request a one-cycle pulse and never raises a registration and an access in the same cycle. It draws ports from a span slightly wider than the allocated area, so misses on both sides occur. It also drives the registration sequence past every limit (device count, line pool, windows per device, end of the port pool), so each failure path is reached from a legal state.

// File: rtl/ior_pkg.sv
package ior_pkg;
    localparam int N_IRQ = 10;
    localparam logic [7:0] NO_IRQ = 8'hFF;

    typedef enum logic {OP_DEV = 1'b0, OP_BAR = 1'b1} reg_op_e;

    // Ordered pool of legacy lines handed to devices.
    function automatic logic [7:0] irq_at(input logic [3:0] idx);
        case (idx)
            4'd0: irq_at = 8'd3;
            4'd1: irq_at = 8'd5;
            4'd2: irq_at = 8'd6;
            4'd3: irq_at = 8'd7;
            4'd4: irq_at = 8'd9;
            4'd5: irq_at = 8'd10;
            4'd6: irq_at = 8'd11;
            4'd7: irq_at = 8'd12;
            4'd8: irq_at = 8'd14;
            4'd9: irq_at = 8'd15;
            default: irq_at = NO_IRQ;
        endcase
    endfunction
endpackage

// File: rtl/ior_alloc.sv
module ior_alloc
    import ior_pkg::*;
#(
    parameter int N_DEV = 12,
    parameter int N_BAR = 6,
    parameter int PORT_W = 16,
    parameter int WIN = 16,
    parameter logic [PORT_W-1:0] BASE_LO = 16'hC000,
    parameter logic [PORT_W-1:0] BASE_HI = 16'hC100,
    localparam int DEV_W = $clog2(N_DEV),
    localparam int BAR_W = $clog2(N_BAR),
    localparam int CNT_W = $clog2(N_DEV + 1),
    localparam int BCNT_W = $clog2(N_BAR + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reg_req,
    input  logic reg_op,
    input  logic reg_irq_need,
    input  logic [DEV_W-1:0] reg_dev,
    input  logic reg_hdl,
    output logic rsp_valid,
    output logic rsp_ok,
    output logic [DEV_W-1:0] rsp_dev,
    output logic [BAR_W-1:0] rsp_bar,
    output logic [PORT_W-1:0] rsp_base,
    output logic [7:0] rsp_irq,
    input  logic [DEV_W-1:0] qry_dev,
    output logic [7:0] qry_irq,
    output logic [N_DEV-1:0][N_BAR-1:0][PORT_W-1:0] base_tab,
    output logic [N_DEV-1:0][N_BAR-1:0] hdl_tab,
    output logic [N_DEV-1:0][7:0] irq_tab
);
    typedef struct packed {
        logic [CNT_W-1:0] dev_ct;
        logic [3:0] irq_idx;
        logic [PORT_W:0] next_base;
        logic [N_DEV-1:0][BCNT_W-1:0] bar_ct;
        logic [N_DEV-1:0][7:0] irq_line;
        logic [N_DEV-1:0][N_BAR-1:0][PORT_W-1:0] base;
        logic [N_DEV-1:0][N_BAR-1:0] hdl;
        logic rsp_valid;
        logic rsp_ok;
        logic [DEV_W-1:0] rsp_dev;
        logic [BAR_W-1:0] rsp_bar;
        logic [PORT_W-1:0] rsp_base;
        logic [7:0] rsp_irq;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.rsp_valid = reg_req;
        s_d.rsp_ok = 1'b0;
        s_d.rsp_dev = reg_dev;
        s_d.rsp_bar = '0;
        s_d.rsp_base = '0;
        s_d.rsp_irq = NO_IRQ;
        if (reg_req) begin
            if (reg_op == OP_DEV) begin
                if (int'(s_q.dev_ct) < N_DEV &&
                    !(reg_irq_need && int'(s_q.irq_idx) >= N_IRQ)) begin
                    s_d.rsp_ok = 1'b1;
                    s_d.rsp_dev = DEV_W'(s_q.dev_ct);
                    if (reg_irq_need) begin
                        s_d.irq_line[DEV_W'(s_q.dev_ct)] = irq_at(s_q.irq_idx);
                        s_d.rsp_irq = irq_at(s_q.irq_idx);
                        s_d.irq_idx = s_q.irq_idx + 4'd1;
                    end
                    s_d.dev_ct = s_q.dev_ct + CNT_W'(1);
                end
            end else begin
                if (int'(reg_dev) < int'(s_q.dev_ct)) begin
                    if (int'(s_q.bar_ct[reg_dev]) < N_BAR &&
                        s_q.next_base < {1'b0, BASE_HI}) begin
                        s_d.base[reg_dev][BAR_W'(s_q.bar_ct[reg_dev])] =
                            s_q.next_base[PORT_W-1:0];
                        s_d.hdl[reg_dev][BAR_W'(s_q.bar_ct[reg_dev])] = reg_hdl;
                        s_d.rsp_ok = 1'b1;
                        s_d.rsp_bar = BAR_W'(s_q.bar_ct[reg_dev]);
                        s_d.rsp_base = s_q.next_base[PORT_W-1:0];
                        s_d.bar_ct[reg_dev] = s_q.bar_ct[reg_dev] + BCNT_W'(1);
                        s_d.next_base = s_q.next_base + (PORT_W+1)'(WIN);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            s_q.irq_line <= '1;
            s_q.next_base <= {1'b0, BASE_LO};
            s_q.rsp_irq <= NO_IRQ;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_ok = s_q.rsp_ok;
    assign rsp_dev = s_q.rsp_dev;
    assign rsp_bar = s_q.rsp_bar;
    assign rsp_base = s_q.rsp_base;
    assign rsp_irq = s_q.rsp_irq;
    assign base_tab = s_q.base;
    assign hdl_tab = s_q.hdl;
    assign irq_tab = s_q.irq_line;
    assign qry_irq = (int'(qry_dev) < N_DEV) ? s_q.irq_line[qry_dev] : NO_IRQ;

    // R9
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |=> rsp_valid);
    // R9
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_req |=> !rsp_valid);
    // R5
    base_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.next_base >= $past(s_q.next_base));
    // R1
    dev_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.dev_ct) <= N_DEV);
    // R2
    irq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.irq_idx) <= N_IRQ);
endmodule

// File: rtl/ior_match.sv
module ior_match #(
    parameter int N_DEV = 12,
    parameter int N_BAR = 6,
    parameter int PORT_W = 16,
    parameter int WIN = 16,
    localparam int DEV_W = $clog2(N_DEV),
    localparam int BAR_W = $clog2(N_BAR),
    localparam int OFS_W = $clog2(WIN)
) (
    input  logic [PORT_W-1:0] port,
    input  logic [N_DEV-1:0][N_BAR-1:0][PORT_W-1:0] base_tab,
    input  logic [N_DEV-1:0][N_BAR-1:0] hdl_tab,
    output logic any_hit,
    output logic [DEV_W-1:0] hit_dev,
    output logic [BAR_W-1:0] hit_bar,
    output logic [OFS_W-1:0] hit_ofs
);
    logic [N_DEV-1:0][N_BAR-1:0] hit;

    for (genvar i = 0; i < N_DEV; i++) begin : g_dev
        for (genvar j = 0; j < N_BAR; j++) begin : g_bar
            logic [PORT_W:0] lo, hi, p;
            assign lo = {1'b0, base_tab[i][j]};
            assign hi = lo + (PORT_W+1)'(WIN);
            assign p = {1'b0, port};
            assign hit[i][j] = hdl_tab[i][j] && (p >= lo) && (p < hi);
        end
    end

    // Later (higher device, then higher window) entries override earlier ones.
    always_comb begin
        logic [PORT_W-1:0] sel_base;
        any_hit = 1'b0;
        hit_dev = '0;
        hit_bar = '0;
        sel_base = '0;
        for (int i = 0; i < N_DEV; i++) begin
            for (int j = 0; j < N_BAR; j++) begin
                if (hit[i][j]) begin
                    any_hit = 1'b1;
                    hit_dev = DEV_W'(i);
                    hit_bar = BAR_W'(j);
                    sel_base = base_tab[i][j];
                end
            end
        end
        hit_ofs = OFS_W'(port - sel_base);
    end
endmodule

// File: rtl/ior_resp.sv
module ior_resp
    import ior_pkg::*;
#(
    parameter int N_DEV = 12,
    parameter int N_BAR = 6,
    parameter int WIN = 16,
    localparam int DEV_W = $clog2(N_DEV),
    localparam int BAR_W = $clog2(N_BAR),
    localparam int OFS_W = $clog2(WIN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_valid,
    input  logic acc_write,
    input  logic [N_DEV-1:0] dev_intr,
    input  logic any_hit,
    input  logic [DEV_W-1:0] hit_dev,
    input  logic [BAR_W-1:0] hit_bar,
    input  logic [OFS_W-1:0] hit_ofs,
    input  logic [N_DEV-1:0][7:0] irq_tab,
    output logic out_valid,
    output logic out_hit,
    output logic [DEV_W-1:0] out_dev,
    output logic [BAR_W-1:0] out_bar,
    output logic [OFS_W-1:0] out_ofs,
    output logic [31:0] out_rdata,
    output logic [7:0] out_irq
);
    typedef struct packed {
        logic valid;
        logic hit;
        logic [DEV_W-1:0] dev;
        logic [BAR_W-1:0] bar;
        logic [OFS_W-1:0] ofs;
        logic [31:0] rdata;
        logic [7:0] irq;
    } res_t;

    res_t r_d, r_q;

    always_comb begin
        r_d = '0;
        r_d.irq = NO_IRQ;
        r_d.valid = acc_valid;
        if (acc_valid) begin
            if (any_hit) begin
                r_d.hit = 1'b1;
                r_d.dev = hit_dev;
                r_d.bar = hit_bar;
                r_d.ofs = hit_ofs;
                if (dev_intr[hit_dev]) r_d.irq = irq_tab[hit_dev];
            end else if (!acc_write) begin
                r_d.rdata = 32'hFFFF_FFFF;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
            r_q.irq <= NO_IRQ;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.valid;
    assign out_hit = r_q.hit;
    assign out_dev = r_q.dev;
    assign out_bar = r_q.bar;
    assign out_ofs = r_q.ofs;
    assign out_rdata = r_q.rdata;
    assign out_irq = r_q.irq;

    // R9
    acc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> out_valid);
    // R8
    miss_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> out_irq == NO_IRQ);
    // R6
    hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> out_valid);
    // R7
    hit_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> out_rdata == 32'd0);
endmodule

// File: rtl/ioport_router.sv
module ioport_router #(
    parameter int N_DEV = 12,
    parameter int N_BAR = 6,
    parameter int PORT_W = 16,
    parameter int WIN = 16,
    parameter logic [PORT_W-1:0] BASE_LO = 16'hC000,
    parameter logic [PORT_W-1:0] BASE_HI = 16'hC100,
    localparam int DEV_W = $clog2(N_DEV),
    localparam int BAR_W = $clog2(N_BAR),
    localparam int OFS_W = $clog2(WIN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reg_req,
    input  logic reg_op,
    input  logic reg_irq_need,
    input  logic [DEV_W-1:0] reg_dev,
    input  logic reg_hdl,
    output logic rsp_valid,
    output logic rsp_ok,
    output logic [DEV_W-1:0] rsp_dev,
    output logic [BAR_W-1:0] rsp_bar,
    output logic [PORT_W-1:0] rsp_base,
    output logic [7:0] rsp_irq,
    input  logic [DEV_W-1:0] qry_dev,
    output logic [7:0] qry_irq,
    input  logic acc_valid,
    input  logic acc_write,
    input  logic [PORT_W-1:0] acc_port,
    input  logic [N_DEV-1:0] dev_intr,
    output logic out_valid,
    output logic out_hit,
    output logic [DEV_W-1:0] out_dev,
    output logic [BAR_W-1:0] out_bar,
    output logic [OFS_W-1:0] out_ofs,
    output logic [31:0] out_rdata,
    output logic [7:0] out_irq
);
    logic [N_DEV-1:0][N_BAR-1:0][PORT_W-1:0] base_tab;
    logic [N_DEV-1:0][N_BAR-1:0] hdl_tab;
    logic [N_DEV-1:0][7:0] irq_tab;
    logic any_hit;
    logic [DEV_W-1:0] hit_dev;
    logic [BAR_W-1:0] hit_bar;
    logic [OFS_W-1:0] hit_ofs;

    ior_alloc #(.N_DEV(N_DEV), .N_BAR(N_BAR), .PORT_W(PORT_W), .WIN(WIN),
                .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_alloc (
        .clk(clk), .rst_n(rst_n),
        .reg_req(reg_req), .reg_op(reg_op), .reg_irq_need(reg_irq_need),
        .reg_dev(reg_dev), .reg_hdl(reg_hdl),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_dev(rsp_dev),
        .rsp_bar(rsp_bar), .rsp_base(rsp_base), .rsp_irq(rsp_irq),
        .qry_dev(qry_dev), .qry_irq(qry_irq),
        .base_tab(base_tab), .hdl_tab(hdl_tab), .irq_tab(irq_tab)
    );

    ior_match #(.N_DEV(N_DEV), .N_BAR(N_BAR), .PORT_W(PORT_W), .WIN(WIN)) u_match (
        .port(acc_port), .base_tab(base_tab), .hdl_tab(hdl_tab),
        .any_hit(any_hit), .hit_dev(hit_dev), .hit_bar(hit_bar), .hit_ofs(hit_ofs)
    );

    ior_resp #(.N_DEV(N_DEV), .N_BAR(N_BAR), .WIN(WIN)) u_resp (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .dev_intr(dev_intr),
        .any_hit(any_hit), .hit_dev(hit_dev), .hit_bar(hit_bar), .hit_ofs(hit_ofs),
        .irq_tab(irq_tab),
        .out_valid(out_valid), .out_hit(out_hit), .out_dev(out_dev),
        .out_bar(out_bar), .out_ofs(out_ofs), .out_rdata(out_rdata), .out_irq(out_irq)
    );
endmodule

// File: tb/ioport_router_test.sv
module ioport_router_test;
    localparam int N_DEV = 12;
    localparam int N_BAR = 6;
    localparam int WIN = 16;
    localparam int LO = 16'hC000;
    localparam int HI = 16'hC100;

    logic clk = 0;
    logic rst_n = 0;
    logic reg_req = 0, reg_op = 0, reg_irq_need = 0, reg_hdl = 0;
    logic [3:0] reg_dev = 0;
    logic rsp_valid, rsp_ok;
    logic [3:0] rsp_dev;
    logic [2:0] rsp_bar;
    logic [15:0] rsp_base;
    logic [7:0] rsp_irq;
    logic [3:0] qry_dev = 0;
    logic [7:0] qry_irq;
    logic acc_valid = 0, acc_write = 0;
    logic [15:0] acc_port = 0;
    logic [N_DEV-1:0] dev_intr = 0;
    logic out_valid, out_hit;
    logic [3:0] out_dev;
    logic [2:0] out_bar;
    logic [3:0] out_ofs;
    logic [31:0] out_rdata;
    logic [7:0] out_irq;

    ioport_router uut (.*);

    always #5 clk = ~clk;

    int checks = 0, fails = 0, cycles = 0;
    int m_dev_ct = 0, m_irq_idx = 0, m_next = LO;
    int m_barct[N_DEV];
    int m_irq[N_DEV];
    int m_base[N_DEV][N_BAR];
    bit m_hdl[N_DEV][N_BAR];

    function automatic int pool(input int i);
        case (i)
            0: return 3; 1: return 5; 2: return 6; 3: return 7; 4: return 9;
            5: return 10; 6: return 11; 7: return 12; 8: return 14; default: return 15;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic add_dev(input bit need);
        bit e_ok;
        int e_id, e_irq;
        e_ok = (m_dev_ct < N_DEV) && !(need && m_irq_idx >= 10);
        e_id = m_dev_ct;
        e_irq = 255;
        if (e_ok) begin
            if (need) begin e_irq = pool(m_irq_idx); m_irq_idx++; end
            m_irq[m_dev_ct] = e_irq;
            m_dev_ct++;
        end
        @(negedge clk);
        reg_req = 1; reg_op = 0; reg_irq_need = need;
        @(negedge clk);
        reg_req = 0;
        chk(rsp_valid == 1, "R9 rsp_valid", rsp_valid, 1);
        chk(rsp_ok == e_ok, need ? "R2 add irq dev ok" : "R1 add dev ok", rsp_ok, e_ok);
        if (e_ok) begin
            chk(rsp_dev == e_id, "R1 dev id", rsp_dev, e_id);
            chk(rsp_irq == e_irq, "R2 irq line", rsp_irq, e_irq);
        end
    endtask

    task automatic add_bar(input int dev, input bit hdl);
        bit e_ok;
        int e_bar, e_base;
        e_ok = (dev < m_dev_ct) && (m_barct[dev] < N_BAR) && (m_next < HI);
        e_bar = 0; e_base = m_next;
        if (e_ok) begin
            e_bar = m_barct[dev];
            m_base[dev][e_bar] = m_next;
            m_hdl[dev][e_bar] = hdl;
            m_barct[dev]++;
            m_next += WIN;
        end
        @(negedge clk);
        reg_req = 1; reg_op = 1; reg_dev = 4'(dev); reg_hdl = hdl;
        @(negedge clk);
        reg_req = 0;
        chk(rsp_ok == e_ok, "R4 R5 add window ok", rsp_ok, e_ok);
        if (e_ok) begin
            chk(rsp_base == 16'(e_base), "R5 window base", rsp_base, e_base);
            chk(rsp_bar == 3'(e_bar), "R5 window index", rsp_bar, e_bar);
        end
    endtask

    task automatic access(input int port, input bit wr, input logic [N_DEV-1:0] intr);
        bit e_hit;
        int e_dev, e_bar, e_ofs, e_irq;
        longint e_rd;
        e_hit = 0; e_dev = 0; e_bar = 0; e_ofs = 0; e_irq = 255;
        for (int i = 0; i < N_DEV; i++)
            for (int j = 0; j < m_barct[i]; j++)
                if (m_hdl[i][j] && port >= m_base[i][j] && port < m_base[i][j] + WIN) begin
                    e_hit = 1; e_dev = i; e_bar = j; e_ofs = port - m_base[i][j];
                end
        if (e_hit && intr[e_dev]) e_irq = m_irq[e_dev];
        e_rd = (!e_hit && !wr) ? 64'hFFFFFFFF : 0;
        @(negedge clk);
        acc_valid = 1; acc_write = wr; acc_port = 16'(port); dev_intr = intr;
        @(negedge clk);
        acc_valid = 0;
        chk(out_valid == 1, "R9 out_valid", out_valid, 1);
        chk(out_hit == e_hit, "R6 hit", out_hit, e_hit);
        if (e_hit) begin
            chk(out_dev == 4'(e_dev) && out_bar == 3'(e_bar), "R6 target",
                {out_dev, out_bar}, {4'(e_dev), 3'(e_bar)});
            chk(out_ofs == 4'(e_ofs), "R6 offset", out_ofs, e_ofs);
        end
        chk(out_rdata == 32'(e_rd), "R7 miss data", out_rdata, e_rd);
        chk(out_irq == 8'(e_irq), "R8 irq route", out_irq, e_irq);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++; checks++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd7));
        for (int i = 0; i < N_DEV; i++) begin
            m_barct[i] = 0; m_irq[i] = 255;
            for (int j = 0; j < N_BAR; j++) begin m_base[i][j] = 0; m_hdl[i][j] = 0; end
        end
        repeat (3) @(negedge clk);
        chk(rsp_valid == 0 && out_valid == 0, "R9 reset idle", {rsp_valid, out_valid}, 0);
        qry_dev = 0; #1;
        chk(qry_irq == 8'hFF, "R3 reset query", qry_irq, 8'hFF);
        rst_n = 1;
        access(LO, 0, '0);                 // R7 empty table read miss
        add_bar(0, 1);                     // R4 unregistered device
        for (int i = 0; i < 11; i++) add_dev(1);   // R2 eleventh fails
        add_dev(0); add_dev(0);            // R2 no-irq still works
        add_dev(0);                        // R1 full
        for (int i = 0; i < N_DEV + 2; i++) begin
            qry_dev = 4'(i); #1;
            chk(qry_irq == 8'(i < N_DEV ? m_irq[i] : 255), "R3 query", qry_irq,
                i < N_DEV ? m_irq[i] : 255);
        end
        for (int k = 0; k < 7; k++) add_bar(0, 1);  // R4 seventh fails
        add_bar(13, 1);                    // R4 bad index
        for (int k = 0; k < 12; k++) add_bar(1 + int'($urandom % 11), ($urandom % 4) != 0);
        add_bar(5, 1);                     // R5 pool exhausted
        for (int n = 0; n < 400; n++)
            access(LO - 8 + int'($urandom % 280), $urandom % 2, N_DEV'($urandom));
        access(LO + 5 * WIN + WIN - 1, 0, '1);   // R6 last port of a window
        access(HI, 0, '1);                      // R7 just past the pool
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule